// File: doc/BRIEF.md
# Frame Boundary and Stall Event Monitor

This block watches the sample-input handshake of a frame-based transform engine. The engine raises a "need sample" strobe whenever it wants the next input sample. The monitor turns that strobe into the stream's ready signal. It keeps a position counter inside the frame, and it raises event outputs for frame start, a framing mismatch against the configured length, and input starvation. It never touches sample data. In non-realtime mode it also asks the engine to stall while starved.

The frame length is N = 2^L, where L is taken from `frame_log2` and forced into the range 3..16. A *slot* is one cycle in which the frame position advances. In non-realtime mode a slot is an accepted sample. In realtime mode a slot is any cycle with the need strobe high, because a missing sample is consumed anyway and the frame is corrupted. The tlast checks are made per slot, so they follow the engine's demand and not the source's timing. The frame-start and tlast events are registered and appear one cycle after their slot. Ready, halt and stall are combinational from the inputs.

A three-state machine tracks the frame. `FR_IDLE` waits at position 0 for the first slot of a frame. `FR_BODY` covers positions 1..N-2. `FR_TAIL` is position N-1, the expected last sample. Its transitions are:
- *open*: FR_IDLE to FR_BODY on a slot. This latches the length and pulses frame start.
- *advance*: FR_BODY to FR_BODY on a slot while the next position is below N-1.
- *arm_tail*: FR_BODY to FR_TAIL on the slot that reaches N-1.
- *close*: FR_TAIL to FR_IDLE on a slot, whether or not tlast was present.

Every state holds when no slot occurs, when the clock enable is low, or during a stall.

Top module: `fmon_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, all three registered events clear, the machine returns to position 0, and the latched length returns to 2^16. Reset wins over `clk_en`, and `s_tready`, `evt_in_halt` and `stall_req` are low while `rst_n` is low.
- R2: `s_tready` is high exactly when `rst_n`, `clk_en` and `need_sample` are all high. A sample is accepted when `s_tready` and `s_tvalid` are both high.
- R3: `evt_frame_start` is high for one cycle, in the cycle after the first slot of a frame (the slot at position 0).
- R4: `evt_tlast_missing` is high for one cycle after a slot at position N-1 that does not carry an accepted sample with `s_tlast` high.
- R5: `evt_tlast_unexpected` is high for one cycle after every accepted sample that has `s_tlast` high at a position other than N-1. Several early tlasts in one frame give several pulses.
- R6: `evt_in_halt` is high on every cycle where `rst_n`, `clk_en` and `need_sample` are high and `s_tvalid` is low.
- R7: With `rt_mode`=0, `stall_req` equals `evt_in_halt` and a starved cycle does not advance the position. With `rt_mode`=1, `stall_req` stays low and a starved need cycle counts as a slot; that slot never raises R5.
- R8: With `clk_en` low, the position, state, latched length and registered events all hold their values.
- R9: The length is latched at the first slot of each frame. A change of `frame_log2` during a frame has no effect until the next frame opens.
- R10: A `frame_log2` value below 3 acts as 3, and a value above 16 acts as 16.
- R11: After the slot at position N-1 the position returns to 0 and the next slot opens a new frame, whether or not tlast was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, priority over clk_en |
| clk_en | input | 1 | Clock enable; low freezes all state |
| rt_mode | input | 1 | 1 = realtime (starvation consumes a slot), 0 = non-realtime (stall) |
| frame_log2 | input | 5 | log2 of the frame length, clamped to 3..16 |
| need_sample | input | 1 | Engine strobe: wants a sample this cycle |
| s_tvalid | input | 1 | Input stream valid |
| s_tlast | input | 1 | Input stream last-of-frame marker |
| s_tready | output | 1 | Input stream ready |
| evt_frame_start | output | 1 | One-cycle pulse after a frame's first slot |
| evt_tlast_missing | output | 1 | One-cycle pulse: tlast absent at position N-1 |
| evt_tlast_unexpected | output | 1 | One-cycle pulse per early tlast |
| evt_in_halt | output | 1 | Level: engine starved this cycle |
| stall_req | output | 1 | Non-realtime stall request to the engine |

## Verification
A wrong frame position is visible only through the tlast events and the frame-start pulse. A counter that has slipped by one gives a spurious missing pulse, followed by an unexpected pulse on the true last sample, within a single frame. That is at most N slots after the fault. A wrong length latch or clamp shifts the expected tail by a whole power of two, so the first frame after the fault already shows the error. Errors in mode selection or freezing show at once on the combinational ready, halt and stall outputs, or one cycle later as a pulse in the wrong place. The bench compares all six outputs on every clock against a behavioural model.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

    // Frame tracking states: position 0, positions 1..N-2, position N-1.
    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_BODY = 2'd1,
        FR_TAIL = 2'd2
    } fr_state_e;

    // Force a requested log2 length into the legal window.
    function automatic int clamp_log2(input int req, input int lo, input int hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/fmon_slot_gen.sv
// Combinational handshake decode: ready, accept, slot, starvation, stall.
module fmon_slot_gen (
    input  logic rst_n,
    input  logic clk_en,
    input  logic rt_mode,
    input  logic need_sample,
    input  logic s_tvalid,
    output logic s_tready,
    output logic accept,
    output logic slot,
    output logic starved,
    output logic stall_req
);
    logic live;

    always_comb begin
        live      = rst_n & clk_en & need_sample;
        s_tready  = live;
        accept    = live & s_tvalid;
        starved   = live & ~s_tvalid;
        // realtime: a starved demand still consumes a position
        slot      = accept | (starved & rt_mode);
        stall_req = starved & ~rt_mode;
    end

    always_comb begin
        if (rst_n && clk_en) begin
            assert_slot_needs_demand_R7: assert (!slot || need_sample);
        end
    end

endmodule

// File: rtl/fmon_len_sel.sv
// Latches the clamped frame length at frame open and gives the last index.
module fmon_len_sel #(
    parameter int LOG2_W   = 5,
    parameter int CNT_W    = 16,
    parameter int MIN_LOG2 = 3,
    parameter int MAX_LOG2 = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              capture,
    input  logic [LOG2_W-1:0] frame_log2,
    output logic [CNT_W-1:0]  last_idx
);
    import fmon_pkg::*;

    localparam logic [LOG2_W-1:0] LEN_RESET = LOG2_W'(MAX_LOG2);

    logic [LOG2_W-1:0] len_q;
    logic [LOG2_W-1:0] len_clamped;
    logic [CNT_W:0]    frame_n;

    always_comb begin
        len_clamped = LOG2_W'(clamp_log2(int'(frame_log2), MIN_LOG2, MAX_LOG2));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= LEN_RESET;
        end else if (clk_en && capture) begin
            len_q <= len_clamped;
        end
    end

    always_comb begin
        frame_n  = (CNT_W+1)'(1) << len_q;
        last_idx = CNT_W'(frame_n - (CNT_W+1)'(1));
    end

    assert_len_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q >= LOG2_W'(MIN_LOG2)) && (len_q <= LOG2_W'(MAX_LOG2)));

    assert_len_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(len_q));

endmodule

// File: rtl/fmon_frame_fsm.sv
// Frame position state machine and registered event outputs.
module fmon_frame_fsm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             slot,
    input  logic             accept,
    input  logic             s_tlast,
    input  logic [CNT_W-1:0] last_idx,
    output logic             at_open,
    output logic [CNT_W-1:0] position,
    output logic             evt_frame_start,
    output logic             evt_tlast_missing,
    output logic             evt_tlast_unexpected
);
    import fmon_pkg::*;

    fr_state_e        state_q, state_d;
    logic [CNT_W-1:0] pos_q, pos_d;
    logic             fs_d, miss_d, unx_d;
    logic             fs_q, miss_q, unx_q;
    logic             tlast_hit;

    // next-state and position
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (slot) begin
            unique case (state_q)
                FR_IDLE: begin
                    state_d = FR_BODY;
                    pos_d   = CNT_W'(1);
                end
                FR_BODY: begin
                    pos_d = pos_q + CNT_W'(1);
                    if (pos_d == last_idx) state_d = FR_TAIL;
                end
                FR_TAIL: begin
                    state_d = FR_IDLE;
                    pos_d   = '0;
                end
                default: begin
                    state_d = FR_IDLE;
                    pos_d   = '0;
                end
            endcase
        end
    end

    // event decode
    always_comb begin
        tlast_hit = accept & s_tlast;
        fs_d      = 1'b0;
        miss_d    = 1'b0;
        unx_d     = 1'b0;
        unique case (state_q)
            FR_IDLE: begin
                fs_d  = slot;
                unx_d = tlast_hit;
            end
            FR_BODY: begin
                unx_d = tlast_hit;
            end
            FR_TAIL: begin
                miss_d = slot & ~tlast_hit;
            end
            default: begin
                fs_d = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            pos_q   <= '0;
        end else if (clk_en) begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q   <= 1'b0;
            miss_q <= 1'b0;
            unx_q  <= 1'b0;
        end else if (clk_en) begin
            fs_q   <= fs_d;
            miss_q <= miss_d;
            unx_q  <= unx_d;
        end
    end

    always_comb begin
        at_open              = (state_q == FR_IDLE);
        position             = pos_q;
        evt_frame_start      = fs_q;
        evt_tlast_missing    = miss_q;
        evt_tlast_unexpected = unx_q;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!fs_q && !miss_q && !unx_q && pos_q == '0));

    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_q && clk_en) |=> !fs_q);

    assert_miss_excl_unx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(miss_q && unx_q));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(pos_q) && $stable(state_q)));

    assert_pos_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FR_IDLE) |-> (pos_q != '0 && pos_q <= last_idx));

    assert_idle_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_IDLE) |-> (pos_q == '0));

endmodule

// File: rtl/fmon_top.sv
// Frame boundary and stall event monitor, top level.
module fmon_top #(
    parameter int LOG2_W   = 5,
    parameter int CNT_W    = 16,
    parameter int MIN_LOG2 = 3,
    parameter int MAX_LOG2 = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              rt_mode,
    input  logic [LOG2_W-1:0] frame_log2,
    input  logic              need_sample,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic              evt_frame_start,
    output logic              evt_tlast_missing,
    output logic              evt_tlast_unexpected,
    output logic              evt_in_halt,
    output logic              stall_req
);
    logic             accept;
    logic             slot;
    logic             at_open;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] position;

    fmon_slot_gen u_slot (
        .rst_n       (rst_n),
        .clk_en      (clk_en),
        .rt_mode     (rt_mode),
        .need_sample (need_sample),
        .s_tvalid    (s_tvalid),
        .s_tready    (s_tready),
        .accept      (accept),
        .slot        (slot),
        .starved     (evt_in_halt),
        .stall_req   (stall_req)
    );

    fmon_len_sel #(
        .LOG2_W   (LOG2_W),
        .CNT_W    (CNT_W),
        .MIN_LOG2 (MIN_LOG2),
        .MAX_LOG2 (MAX_LOG2)
    ) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .capture    (slot & at_open),
        .frame_log2 (frame_log2),
        .last_idx   (last_idx)
    );

    fmon_frame_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk                  (clk),
        .rst_n                (rst_n),
        .clk_en               (clk_en),
        .slot                 (slot),
        .accept               (accept),
        .s_tlast              (s_tlast),
        .last_idx             (last_idx),
        .at_open              (at_open),
        .position             (position),
        .evt_frame_start      (evt_frame_start),
        .evt_tlast_missing    (evt_tlast_missing),
        .evt_tlast_unexpected (evt_tlast_unexpected)
    );

    // a stalled cycle must leave the frame position untouched
    assert_stall_holds_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> $stable(position));

    assert_halt_means_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_in_halt |-> (s_tready && !s_tvalid));

    assert_stall_only_nrt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> !rt_mode);

endmodule

// File: tb/fmon_top_bench.sv
module fmon_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       rt_mode = 1'b0;
    logic [4:0] frame_log2 = 5'd3;
    logic       need_sample = 1'b0;
    logic       s_tvalid = 1'b0;
    logic       s_tlast = 1'b0;
    logic       s_tready, evt_frame_start, evt_tlast_missing;
    logic       evt_tlast_unexpected, evt_in_halt, stall_req;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // behavioural model state
    int  m_pos = 0;
    int  m_len = 16;
    bit  e_fs = 0, e_miss = 0, e_unx = 0;

    always #2 clk = ~clk;

    fmon_top u_fmon_top (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rt_mode(rt_mode),
        .frame_log2(frame_log2), .need_sample(need_sample),
        .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .evt_frame_start(evt_frame_start), .evt_tlast_missing(evt_tlast_missing),
        .evt_tlast_unexpected(evt_tlast_unexpected), .evt_in_halt(evt_in_halt),
        .stall_req(stall_req)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (scenario %s) t=%0t actual=%b expected=%b",
                     req, cur_req, $time, act, exp);
        end
    endtask

    // drive one cycle of inputs, check outputs, advance the model
    task automatic step(input bit rs, input bit en, input bit rt, input int lg,
                        input bit nd, input bit vl, input bit ls);
        bit live, acc, slt, strv;
        int lidx, cl;
        @(negedge clk);
        rst_n = rs; clk_en = en; rt_mode = rt; frame_log2 = 5'(lg);
        need_sample = nd; s_tvalid = vl; s_tlast = ls;
        #1;
        live = rs && en && nd;
        acc  = live && vl;
        strv = live && !vl;
        slt  = acc || (strv && rt);
        chk("R2", s_tready, live);
        chk("R6", evt_in_halt, strv);
        chk("R7", stall_req, strv && !rt);
        chk("R3", evt_frame_start, e_fs);
        chk("R4", evt_tlast_missing, e_miss);
        chk("R5", evt_tlast_unexpected, e_unx);
        if (!rs) begin
            m_pos = 0; m_len = 16; e_fs = 0; e_miss = 0; e_unx = 0;
        end else if (en) begin
            cl = (lg < 3) ? 3 : ((lg > 16) ? 16 : lg);
            if (m_pos == 0 && slt) m_len = cl;
            lidx   = (1 << m_len) - 1;
            e_fs   = slt && (m_pos == 0);
            e_miss = slt && (m_pos == lidx) && !(acc && ls);
            e_unx  = acc && ls && (m_pos != lidx);
            if (slt) m_pos = (m_pos == lidx) ? 0 : m_pos + 1;
        end
    endtask

    // one frame of n accepted samples; tlast on listed 1-based positions
    task automatic frame(input int lg, input int n, input int last_at1, input int last_at2);
        for (int i = 1; i <= n; i++)
            step(1, 1, 0, lg, 1, 1, (i == last_at1) || (i == last_at2));
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit [15:0] lf;
        cur_req = "R1";
        for (int i = 0; i < 3; i++) step(0, 0, 0, 3, 1, 1, 1);
        step(1, 1, 0, 3, 0, 0, 0);

        cur_req = "R3";
        frame(3, 8, 8, 0);
        step(1, 1, 0, 3, 0, 0, 0);

        cur_req = "R4";   // tlast absent on the 8th sample
        frame(3, 8, 0, 0);
        cur_req = "R11";  // restart after missing tlast
        frame(3, 8, 8, 0);

        cur_req = "R5";   // two early tlasts, then the proper one
        frame(3, 8, 2, 5);
        frame(3, 8, 8, 3);

        cur_req = "R6";   // non-realtime starvation mid-frame
        for (int i = 1; i <= 8; i++) begin
            if (i == 4) begin
                step(1, 1, 0, 3, 1, 0, 0);
                step(1, 1, 0, 3, 1, 0, 0);
            end
            step(1, 1, 0, 3, 1, 1, i == 8);
        end

        cur_req = "R7";   // realtime starvation consumes positions
        for (int i = 1; i <= 8; i++)
            step(1, 1, 1, 3, 1, (i != 3 && i != 8), 1'b1);
        step(1, 1, 1, 3, 1, 1, 0);
        for (int i = 2; i <= 8; i++) step(1, 1, 1, 3, 1, 1, i == 8);

        cur_req = "R8";   // freeze with an event pending and inputs active
        frame(3, 7, 3, 0);
        step(1, 1, 0, 3, 1, 1, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 5, 1, 1, 1);
        step(1, 1, 0, 3, 0, 0, 0);

        cur_req = "R9";   // length change mid-frame ignored
        step(1, 1, 0, 3, 1, 1, 0);
        for (int i = 2; i <= 8; i++) step(1, 1, 0, 4, 1, 1, i == 8);
        frame(4, 16, 16, 0);

        cur_req = "R10";  // low values act as 3, high values as 16
        frame(1, 8, 8, 0);
        frame(0, 8, 8, 0);
        frame(20, 8, 8, 0);
        step(1, 1, 0, 20, 1, 1, 0);
        cur_req = "R1";   // reset mid-frame returns to position 0
        step(0, 1, 0, 3, 1, 1, 0);
        step(0, 0, 0, 3, 1, 1, 0);
        frame(3, 8, 8, 0);

        cur_req = "R2";   // pseudo-random mixed traffic
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(!(lf[15:10] == 6'd0), lf[9:7] != 3'd0, lf[6], 3 + int'(lf[1:0] == 2'd0),
                 lf[5] | lf[4], lf[3] | lf[2], lf[11] & lf[8] & lf[0]);
        end
        step(1, 1, 0, 3, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule